// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous 16-bit SRAM

This block sits between an internal request stream and an external asynchronous static RAM that is sixteen bits wide and split into two byte lanes. Each accepted request is one word access, read or write, with a two-bit lane mask. The controller turns it into a strobe sequence on the memory's active-low chip select, write strobe, output-enable and two lane selects. The phase lengths are whole clock cycles, and each one is derived at elaboration from a nanosecond limit and the clock period.

The request side uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. A requester that sees `req_ready` low must keep `req_valid` high and keep the request fields steady until the transfer edge. Completion is reported by a one-cycle `rsp_done` pulse that carries no back-pressure. For a read, `rsp_rdata` is valid in that cycle. The shared data pins are split into an output word, an input word and a drive enable. The controller drives the pins only while the memory has released them, and a read is always followed by a release gap before any write can drive.

With a 10 ns clock and the default limits, both a write and a read keep the controller busy for three cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever idle, all five memory strobes are high, `mem_dq_oe` is low, `rsp_done` is low and `req_ready` is high. `req_ready` is low from the cycle after a transfer edge until the access and its trailing cycles are over.
- R2: A write holds `mem_ce_n` and `mem_we_n` low and `mem_oe_n` high for exactly WR_LOW cycles, starting the cycle after the transfer edge. `mem_addr` equals the request address throughout.
- R3: Lane mapping: `req_be[0]` selects data bits 7:0 and drives `mem_lb_n` low, and `req_be[1]` selects bits 15:8 and drives `mem_ub_n` low. This holds only during the write-strobe or read-strobe cycles. At all other times both lane selects are high.
- R4: `mem_dq_oe` rises one cycle after `mem_we_n` falls and drops one cycle after `mem_we_n` rises. While it is high, `mem_dq_out` equals the request write data.
- R5: A write ends by raising `mem_we_n`, `mem_ce_n` and both lane selects in the same cycle. `mem_addr` stays unchanged in that cycle (zero address hold).
- R6: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly RD_LEN cycles, starting the cycle after the transfer edge, with `mem_dq_oe` low.
- R7: `rsp_done` pulses for one cycle. For a write, the pulse falls in the cycle in which the write ends. For a read, it falls in the cycle after the last read-strobe cycle, and `rsp_rdata` then holds `mem_dq_in` as sampled at the end of that last read cycle. Bits of an unselected lane read as zero.
- R8: After a read, all strobes stay high and `req_ready` stays low for TURN_LEN cycles before the next request can be taken.
- R9: Each phase length is the ceiling of its limit divided by the clock period, and at least 1. The write-low length is the largest of the pulse width, the data setup plus one cycle, and the write cycle minus one. RD_LEN is the largest of the address, output-enable and read-cycle limits. TURN_LEN comes from the bus-release limit. The defaults give WR_LOW=2, RD_LEN=2 and TURN_LEN=1.
- R10: A request with `req_be`=00 runs the full sequence and produces `rsp_done`, but it never pulls a lane select low. Memory contents are unchanged, and a read with `req_be`=00 returns zero.
- R11: `mem_dq_oe` is never high while `mem_ce_n` and `mem_oe_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` after a read |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 16 | Data toward the memory pins |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data sampled from the memory pins |

## Verification
The checker's properties take two things for granted. First, reset is held low across at least one rising clock edge, so the first `$past` values are reset values. Second, `req_valid` is a clean level sampled only at rising edges. The properties assume nothing about `mem_dq_in`.

The bench drives every input just after a falling edge, and it keeps `req_valid` and the request fields steady until the model predicts a transfer. That keeps the stimulus inside the back-pressure rule. A behavioural memory in the bench returns a fixed pattern on unselected lanes and when it is not being read. This exposes any lane-masking or capture-timing fault in `rsp_rdata`.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WREC,
    ST_RD,
    ST_TURN
  } phase_e;

  // Whole cycles needed to cover a limit in ns, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned CW       = 2,
  parameter int unsigned WR_LOW   = 2,
  parameter int unsigned RD_LEN   = 2,
  parameter int unsigned TURN_LEN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_last,
  output phase_e        state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output logic          wr_end
);
  phase_e state_q, nxt;

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          nxt     = ST_WR;
          tmr_val = CW'(WR_LOW - 1);
        end else begin
          nxt     = ST_RD;
          tmr_val = CW'(RD_LEN - 1);
        end
      end
      ST_WR:   if (tmr_last) nxt = ST_WREC;
      ST_WREC: nxt = ST_IDLE;
      ST_RD:   if (tmr_last) begin
        nxt      = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = CW'(TURN_LEN - 1);
      end
      ST_TURN: if (tmr_last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt;
  end

  assign state   = state_q;
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_RD) && tmr_last;
  assign wr_end  = (state_q == ST_WR) && tmr_last;
endmodule

// File: rtl/sram_lane_dpath.sv
module sram_lane_dpath
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        state,
  input  logic          accept,
  input  logic          capture,
  input  logic          wr_end,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);
  localparam int unsigned LW = DW / 2;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, lane_mask;
  logic [1:0]    be_q;
  logic          done_q, drv_q;

  // Expand the two lane bits into a word mask.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_mask[g*LW +: LW] = {LW{be_q[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (capture) rdata_q <= mem_dq_in & lane_mask;
      done_q <= capture | wr_end;
      // Drivers trail the write strobe by one cycle on both edges.
      drv_q  <= (state == ST_WR);
    end
  end

  always_comb begin
    mem_ce_n = 1'b1;
    mem_we_n = 1'b1;
    mem_oe_n = 1'b1;
    mem_lb_n = 1'b1;
    mem_ub_n = 1'b1;
    case (state)
      ST_WR: begin
        mem_ce_n = 1'b0;
        mem_we_n = 1'b0;
        mem_lb_n = ~be_q[0];
        mem_ub_n = ~be_q[1];
      end
      ST_RD: begin
        mem_ce_n = 1'b0;
        mem_oe_n = 1'b0;
        mem_lb_n = ~be_q[0];
        mem_ub_n = ~be_q[1];
      end
      default: ;
    endcase
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drv_q;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_WP_NS   = 8,
  parameter int unsigned T_SD_NS   = 6,
  parameter int unsigned T_WC_NS   = 12,
  parameter int unsigned T_AA_NS   = 12,
  parameter int unsigned T_DOE_NS  = 6,
  parameter int unsigned T_RC_NS   = 12,
  parameter int unsigned T_HZ_NS   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  // R9: phase lengths in whole cycles
  localparam int unsigned WP_C     = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned SD_C     = ns_to_cyc(T_SD_NS, CLK_NS);
  localparam int unsigned WC_C     = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WR_LOW   = max2(max2(WP_C, SD_C + 1), max2(WC_C - 1, 1));
  localparam int unsigned RD_LEN   = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)),
                                          ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned TURN_LEN = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned MAX_LEN  = max2(max2(WR_LOW, RD_LEN), TURN_LEN);
  localparam int unsigned CW       = $clog2(MAX_LEN + 1);

  phase_e        state;
  logic          tmr_load, tmr_last, accept, capture, wr_end;
  logic [CW-1:0] tmr_val;

  sram_lane_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  sram_lane_fsm #(.CW(CW), .WR_LOW(WR_LOW), .RD_LEN(RD_LEN), .TURN_LEN(TURN_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_last(tmr_last), .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .accept(accept), .capture(capture), .wr_end(wr_end)
  );

  sram_lane_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .accept(accept), .capture(capture),
    .wr_end(wr_end), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic          mem_dq_oe
);
  a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !(!mem_ce_n && !mem_oe_n));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done));

  a_r2_write_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  a_r3_lanes_parked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lb_n && mem_ub_n));

  a_r4_drive_late_on: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  a_r4_drive_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> mem_dq_oe);

  a_r4_drive_hold_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  a_r4_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && $past(mem_we_n)) |-> !mem_dq_oe);

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) || (!mem_ce_n && $past(!mem_ce_n))) |-> $stable(mem_addr));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic ce, we, oe, ub, lb, dqoe, done, has_rd;
    logic [15:0] addr, wdata, rdata;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0] req_be;
  logic req_ready, rsp_done;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_in;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];
  logic [15:0] refm[int];
  logic [15:0] sram[int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // R9: lengths from the timing limits, computed here independently
  function automatic int cdiv(input int t);
    int c;
    c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  int WRL, RDL, TRN;

  function automatic logic [15:0] rd_mem(input logic [15:0] a, input bit use_ref);
    if (use_ref) return refm.exists(int'(a)) ? refm[int'(a)] : 16'h0000;
    return sram.exists(int'(a)) ? sram[int'(a)] : 16'h0000;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural memory: presents data at the falling edge, stores on rising edges.
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = {mem_ub_n ? 8'hA5 : rd_mem(mem_addr, 0)[15:8],
                   mem_lb_n ? 8'hA5 : rd_mem(mem_addr, 0)[7:0]};
    else
      mem_dq_in = 16'h5A5A;
    if (rst_n) check("R11", "bus contention", {15'd0, mem_dq_oe && !mem_ce_n && !mem_oe_n}, 16'd0);
  end

  always @(posedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = rd_mem(mem_addr, 0);
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      sram[int'(mem_addr)] = w;
    end
  end

  task automatic push_access(input logic w, input logic [15:0] a, d, input logic [1:0] be);
    exp_t e;
    if (w) begin
      logic [15:0] m;
      m = rd_mem(a, 1);
      if (be[0]) m[7:0]  = d[7:0];
      if (be[1]) m[15:8] = d[15:8];
      refm[int'(a)] = m;
      for (int i = 0; i < WRL; i++) begin
        e = '{ce:0, we:0, oe:1, ub:~be[1], lb:~be[0], dqoe:(i > 0), done:0, has_rd:0,
              addr:a, wdata:d, rdata:16'h0};
        q.push_back(e);
      end
      e = '{ce:1, we:1, oe:1, ub:1, lb:1, dqoe:1, done:1, has_rd:0, addr:a, wdata:d, rdata:16'h0};
      q.push_back(e);
    end else begin
      logic [15:0] r;
      r = rd_mem(a, 1) & {{8{be[1]}}, {8{be[0]}}};
      for (int i = 0; i < RDL; i++) begin
        e = '{ce:0, we:1, oe:0, ub:~be[1], lb:~be[0], dqoe:0, done:0, has_rd:0,
              addr:a, wdata:d, rdata:16'h0};
        q.push_back(e);
      end
      for (int i = 0; i < TRN; i++) begin
        e = '{ce:1, we:1, oe:1, ub:1, lb:1, dqoe:0, done:(i == 0), has_rd:(i == 0),
              addr:a, wdata:d, rdata:r};
        q.push_back(e);
      end
    end
  endtask

  // One cycle: compare outputs to the model, then drive new inputs.
  task automatic step(input logic v, input logic w, input logic [15:0] a, d,
                      input logic [1:0] be, output logic acc);
    exp_t e;
    logic rdy;
    @(negedge clk);
    rdy = (q.size() == 0);
    if (rdy) e = '{ce:1, we:1, oe:1, ub:1, lb:1, dqoe:0, done:0, has_rd:0,
                   addr:16'h0, wdata:16'h0, rdata:16'h0};
    else     e = q.pop_front();
    check("R1 R8", "req_ready", {15'd0, req_ready}, {15'd0, rdy});
    check("R2 R6 R9", "ce_n", {15'd0, mem_ce_n}, {15'd0, e.ce});
    check("R2 R6 R9", "we_n", {15'd0, mem_we_n}, {15'd0, e.we});
    check("R2 R6 R8", "oe_n", {15'd0, mem_oe_n}, {15'd0, e.oe});
    check("R3 R5 R10", "lanes", {14'd0, mem_ub_n, mem_lb_n}, {14'd0, e.ub, e.lb});
    check("R4", "dq_oe", {15'd0, mem_dq_oe}, {15'd0, e.dqoe});
    check("R7", "rsp_done", {15'd0, rsp_done}, {15'd0, e.done});
    if (!rdy && (!e.ce || e.dqoe)) check("R5", "mem_addr", mem_addr, e.addr);
    if (e.dqoe) check("R4", "dq_out", mem_dq_out, e.wdata);
    if (e.has_rd) check("R7 R10", "rsp_rdata", rsp_rdata, e.rdata);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    acc = v && rdy;
    if (acc) push_access(w, a, d, be);
  endtask

  task automatic do_op(input logic w, input logic [15:0] a, d, input logic [1:0] be);
    logic acc;
    acc = 1'b0;
    while (!acc) step(1'b1, w, a, d, be, acc);
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0, 16'h0, 2'b00, acc);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    WRL = imax(imax(cdiv(8), cdiv(6) + 1), imax(cdiv(12) - 1, 1));
    RDL = imax(imax(cdiv(12), cdiv(6)), cdiv(12));
    TRN = cdiv(6);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset strobes", {11'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 16'h001F);
    check("R1", "reset ready/done/oe", {13'd0, req_ready, rsp_done, mem_dq_oe}, 16'h0004);
    rst_n = 1'b1;
    idle(2);
    do_op(1, 16'h0000, 16'h1234, 2'b11);
    do_op(0, 16'h0000, 16'h0000, 2'b11);          // R7 full word
    do_op(1, 16'hFFFF, 16'hABCD, 2'b01);          // R3 low lane only
    idle(1);
    do_op(1, 16'hFFFF, 16'h99EF, 2'b10);          // R3 high lane only
    do_op(0, 16'hFFFF, 16'h0, 2'b11);
    do_op(0, 16'hFFFF, 16'h0, 2'b01);             // R7 masked upper
    do_op(0, 16'hFFFF, 16'h0, 2'b10);             // R7 masked lower
    do_op(1, 16'h0010, 16'h5555, 2'b00);          // R10 no lane
    do_op(0, 16'h0010, 16'h0, 2'b11);
    do_op(0, 16'h0010, 16'h0, 2'b00);             // R10 read none
    do_op(1, 16'h0001, 16'hBEEF, 2'b11);          // R8 write right after read
    do_op(0, 16'h0001, 16'h0, 2'b11);
    for (int i = 0; i < 60; i++) begin
      do_op((i % 3) != 0, 16'((i * 37) % 8), 16'(i * 16'h1357 + 7), 2'(i % 4));
      if (i % 5 == 0) idle(i % 3);
    end
    idle(5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule